// File: doc/BRIEF.md
# Single-Wire Bus Master Sequencer

This block is the timing engine of a master on a single open-drain data line with a pull-up resistor. A host issues one operation at a time: a bus reset, a single-bit write, or a single-bit read. The sequencer then pulls the line low through an output enable for the required time, releases it, samples the synchronized line at a fixed instant where the operation calls for it, and waits out the recovery time. When the operation is complete it raises `done_o` for one clock. Byte framing, device commands and checksums are handled by logic above this block.

Two timing sets are built in, standard and overdrive. The speed input is captured when a command is accepted and governs every waveform of that operation. A standard-speed reset holds the line low for 480 µs, which returns every attached device to standard speed. The high window after a reset is 480 µs at standard speed and 48 µs at overdrive, so devices with slower presence timing can still take part. All timing comes from an internal half-microsecond tick, derived from the parameter `CLK_PER_US` (clock cycles per microsecond, which must be even and at least 4).

Top module: `sline_master`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `line_oe_o`, `presence_o` and `rbit_o` are all 0.
- R2: A reset command (opcode 2'b00) at standard speed drives the line low for exactly 480 µs and keeps `busy_o` high for exactly 960 µs.
- R3: A reset command at overdrive speed drives the line low for exactly 70 µs and keeps `busy_o` high for exactly 118 µs.
- R4: A reset samples the line once, 70 µs after release at standard speed or 8.5 µs at overdrive. `presence_o` becomes 1 if the line was low at that instant and 0 otherwise, and it keeps its value through all other operations.
- R5: A write command (opcode 2'b01) drives the line low for 6 µs at standard speed and 1 µs at overdrive when `cmd_bit_i` is 1. When `cmd_bit_i` is 0 it drives low for 60 µs at standard speed and 7.5 µs at overdrive. Every operation begins by driving the line low in its first busy cycle.
- R6: A read command (opcode 2'b10) drives the line low for 6 µs at standard speed or 1 µs at overdrive. It samples the line 9 µs (standard) or 1 µs (overdrive) after release. `rbit_o` takes the sampled level (1 = high) and keeps it through all other operations.
- R7: Every write or read keeps `busy_o` high for 75 µs at standard speed and 12 µs at overdrive. This is a 70 µs or 10 µs slot followed by a 5 µs or 2 µs recovery gap.
- R8: `done_o` is high for exactly one clock per operation, in the first cycle in which `busy_o` is low again.
- R9: A command strobe while `busy_o` is high has no effect. The running operation keeps its timing and no second operation follows it.
- R10: Opcode 2'b11 is ignored: `busy_o` and `line_oe_o` stay 0.
- R11: The speed is captured when a command is accepted. Changes on `od_speed_i` during an operation do not alter it.
- R12: `line_oe_o` is never high while `busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command strobe, taken when idle |
| cmd_op_i | input | 2 | Opcode: 00 reset, 01 write bit, 10 read bit, 11 none |
| cmd_bit_i | input | 1 | Bit value for a write |
| od_speed_i | input | 1 | 1 selects overdrive timing, 0 standard |
| line_i | input | 1 | Raw level of the data line |
| line_oe_o | output | 1 | 1 pulls the data line low |
| busy_o | output | 1 | High for the whole operation |
| done_o | output | 1 | One-clock completion pulse |
| presence_o | output | 1 | Result of the last reset's presence sample |
| rbit_o | output | 1 | Result of the last read slot |

## Verification
Every phase boundary is a comparison of the tick count against a window chosen at acceptance. A wrong captured opcode, speed or window therefore shows up on `line_oe_o` as a wrong low width by the end of the first phase, and on `busy_o` as a wrong total length, both within one operation. A sampling instant that is off by one tick can only be seen through a slave response whose edge lies close to that instant. For this reason the presence check places one response window that narrowly covers the sample point and one that ends just before it. A result register that updates at the wrong time shows up as a changed `presence_o` or `rbit_o` after an operation of a different kind.

// File: rtl/sline_pkg.sv
package sline_pkg;

  // Width of the half-microsecond tick count; the longest operation is 1920 ticks
  localparam int TW = 12;

  typedef enum logic [1:0] {
    OP_RESET = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_NONE  = 2'b11
  } sl_op_e;

  // Phase boundaries of one operation, in half-microsecond ticks from its start
  typedef struct packed {
    logic [TW-1:0] low;   // line driven low while count < low
    logic [TW-1:0] samp;  // count reached at the sample instant
    logic [TW-1:0] fin;   // count reached when the operation ends
  } sl_win_t;

  // Durations in microseconds times two
  localparam int RST_LOW_STD   = 960;
  localparam int RST_LOW_OD    = 140;
  localparam int RST_HIGH_STD  = 960;
  localparam int RST_HIGH_OD   = 96;
  localparam int PRES_SMP_STD  = 140;
  localparam int PRES_SMP_OD   = 17;
  localparam int SHORT_LOW_STD = 12;
  localparam int SHORT_LOW_OD  = 2;
  localparam int LONG_LOW_STD  = 120;
  localparam int LONG_LOW_OD   = 15;
  localparam int RD_SMP_STD    = 18;
  localparam int RD_SMP_OD     = 2;
  localparam int SLOT_STD      = 140;
  localparam int SLOT_OD       = 20;
  localparam int REC_STD       = 10;
  localparam int REC_OD        = 4;

  function automatic logic [TW-1:0] tk(input int half_us);
    return TW'(half_us);
  endfunction

  function automatic sl_win_t win_of(input sl_op_e op, input logic one, input logic od);
    sl_win_t w;
    int lo;
    int fin;
    case (op)
      OP_RESET: begin
        lo    = od ? RST_LOW_OD : RST_LOW_STD;
        w.low  = tk(lo);
        w.samp = tk(lo + (od ? PRES_SMP_OD : PRES_SMP_STD));
        w.fin  = tk(lo + (od ? RST_HIGH_OD : RST_HIGH_STD));
      end
      OP_READ: begin
        lo    = od ? SHORT_LOW_OD : SHORT_LOW_STD;
        fin   = od ? (SLOT_OD + REC_OD) : (SLOT_STD + REC_STD);
        w.low  = tk(lo);
        w.samp = tk(lo + (od ? RD_SMP_OD : RD_SMP_STD));
        w.fin  = tk(fin);
      end
      default: begin
        if (one) lo = od ? SHORT_LOW_OD : SHORT_LOW_STD;
        else     lo = od ? LONG_LOW_OD : LONG_LOW_STD;
        fin   = od ? (SLOT_OD + REC_OD) : (SLOT_STD + REC_STD);
        w.low  = tk(lo);
        w.samp = tk(fin);
        w.fin  = tk(fin);
      end
    endcase
    return w;
  endfunction

endpackage

// File: rtl/sline_sync.sv
module sline_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] st;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st[g] <= 1'b1;
        else        st[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st[g] <= 1'b1;
        else        st[g] <= st[g-1];
      end
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/sline_tick.sv
module sline_tick
  import sline_pkg::*;
#(
  parameter int DIV = 100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          run,
  output logic          tick,
  output logic [TW-1:0] elapsed
);
  localparam int DW = (DIV > 2) ? $clog2(DIV) : 1;

  logic [DW-1:0] div_q;

  assign tick = run && (div_q == DW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= '0;
      elapsed <= '0;
    end else if (clr) begin
      div_q   <= '0;
      elapsed <= '0;
    end else if (run) begin
      div_q <= tick ? '0 : div_q + DW'(1);
      if (tick) elapsed <= elapsed + TW'(1);
    end
  end
endmodule

// File: rtl/sline_seq.sv
module sline_seq
  import sline_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic          cmd_bit,
  input  logic          od_sel,
  input  logic          line_s,
  input  logic          tick,
  input  logic [TW-1:0] elapsed,
  output logic          clr,
  output logic          run,
  output logic          line_oe,
  output logic          busy,
  output logic          done,
  output logic          presence,
  output logic          rbit,
  output logic          pres_samp,
  output logic          bit_samp,
  output logic          od_lat
);
  sl_op_e        op_in;
  sl_op_e        op_q;
  sl_win_t       win_q;
  logic          busy_q, done_q, pres_q, rbit_q, od_q;
  logic          accept, samp_hit, end_hit;
  logic [TW-1:0] next_e;

  assign op_in    = sl_op_e'(cmd_op);
  assign accept   = !busy_q && cmd_valid && (op_in != OP_NONE);
  assign next_e   = elapsed + TW'(1);
  assign samp_hit = busy_q && tick && (next_e == win_q.samp);
  assign end_hit  = busy_q && tick && (next_e == win_q.fin);

  assign pres_samp = samp_hit && (op_q == OP_RESET);
  assign bit_samp  = samp_hit && (op_q == OP_READ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      pres_q <= 1'b0;
      rbit_q <= 1'b0;
      od_q   <= 1'b0;
      op_q   <= OP_NONE;
      win_q  <= '0;
    end else begin
      done_q <= end_hit;
      if (accept) begin
        busy_q <= 1'b1;
        op_q   <= op_in;
        od_q   <= od_sel;
        win_q  <= win_of(op_in, cmd_bit, od_sel);
      end else if (end_hit) begin
        busy_q <= 1'b0;
      end
      if (pres_samp) pres_q <= ~line_s;
      if (bit_samp)  rbit_q <= line_s;
    end
  end

  assign clr      = accept;
  assign run      = busy_q;
  assign line_oe  = busy_q && (elapsed < win_q.low);
  assign busy     = busy_q;
  assign done     = done_q;
  assign presence = pres_q;
  assign rbit     = rbit_q;
  assign od_lat   = od_q;
endmodule

// File: rtl/sline_master.sv
module sline_master
  import sline_pkg::*;
#(
  parameter int CLK_PER_US  = 200,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid_i,
  input  logic [1:0] cmd_op_i,
  input  logic       cmd_bit_i,
  input  logic       od_speed_i,
  input  logic       line_i,
  output logic       line_oe_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       presence_o,
  output logic       rbit_o
);
  localparam int TICK_CYC = CLK_PER_US / 2;

  logic          line_s_w;
  logic          tick_w, clr_w, run_w;
  logic [TW-1:0] elapsed_w;
  logic          pres_samp_w, bit_samp_w, od_lat_w;

  sline_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(line_i), .q(line_s_w)
  );

  sline_tick #(.DIV(TICK_CYC)) tick_i (
    .clk(clk), .rst_n(rst_n), .clr(clr_w), .run(run_w),
    .tick(tick_w), .elapsed(elapsed_w)
  );

  sline_seq seq_i (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid_i), .cmd_op(cmd_op_i), .cmd_bit(cmd_bit_i),
    .od_sel(od_speed_i), .line_s(line_s_w),
    .tick(tick_w), .elapsed(elapsed_w),
    .clr(clr_w), .run(run_w),
    .line_oe(line_oe_o), .busy(busy_o), .done(done_o),
    .presence(presence_o), .rbit(rbit_o),
    .pres_samp(pres_samp_w), .bit_samp(bit_samp_w), .od_lat(od_lat_w)
  );
endmodule

// File: rtl/sline_master_chk.sv
module sline_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [1:0] cmd_op,
  input logic       busy,
  input logic       done,
  input logic       line_oe,
  input logic       presence,
  input logic       rbit,
  input logic       pres_samp,
  input logic       bit_samp,
  input logic       od_lat
);
  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !line_oe);

  p_done_closes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  p_done_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_skip_none_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_valid && cmd_op == 2'b11) |=> !busy);

  p_start_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_valid && cmd_op != 2'b11) |=> (busy && line_oe));

  p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid) |=> (busy || done));

  p_speed_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(od_lat));

  p_pres_update_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(presence) |-> $past(pres_samp));

  p_rbit_update_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rbit) |-> $past(bit_samp));
endmodule

bind sline_master sline_master_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid_i), .cmd_op(cmd_op_i),
  .busy(busy_o), .done(done_o), .line_oe(line_oe_o),
  .presence(presence_o), .rbit(rbit_o),
  .pres_samp(pres_samp_w), .bit_samp(bit_samp_w), .od_lat(od_lat_w)
);

// File: tb/sline_master_tb_top.sv
module sline_master_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int CPU = 4;
  localparam int C   = CPU / 2;   // cycles per half-microsecond

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic       cmd_bit = 1'b0;
  logic       od_sel = 1'b0;
  logic       oe, busy, done, pres, rbit;
  logic       slave_low, line_w;

  int  cyc = 0;
  int  start_cyc = 0;
  int  win_lo = 0;
  int  win_hi = 0;
  bit  win_on = 1'b0;
  int  n_run = 0;
  int  n_fail = 0;
  bit  finished = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign slave_low = win_on && ((cyc - start_cyc) >= win_lo) && ((cyc - start_cyc) < win_hi);
  assign line_w    = !(oe || slave_low);

  sline_master #(.CLK_PER_US(CPU), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_bit_i(cmd_bit), .od_speed_i(od_sel), .line_i(line_w),
    .line_oe_o(oe), .busy_o(busy), .done_o(done),
    .presence_o(pres), .rbit_o(rbit)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // kinds: 0 reset, 1 write-zero, 2 write-one, 3 read; results in half-microseconds
  function automatic int e_low(input int k, input bit od);
    case (k)
      0:       return od ? 70 * 2 : 480 * 2;
      1:       return od ? 15 : 60 * 2;
      default: return od ? 1 * 2 : 6 * 2;
    endcase
  endfunction

  function automatic int e_fin(input int k, input bit od);
    if (k == 0) return od ? (70 + 48) * 2 : (480 + 480) * 2;
    return od ? (10 + 2) * 2 : (70 + 5) * 2;
  endfunction

  task automatic run_op(input logic [1:0] op, input logic bv, input logic od,
                        input int lo, input int hi, input int poke, input int pk,
                        output int oe_n, output int busy_n, output int done_n, output int rises);
    int  done_at;
    bit  prev_oe;
    oe_n = 0; busy_n = 0; done_n = 0; rises = 0; done_at = -1; prev_oe = 1'b0;
    @(negedge clk);
    cmd_op = op; cmd_bit = bv; od_sel = od; cmd_valid = 1'b1;
    win_lo = lo; win_hi = hi;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    start_cyc = cyc;
    win_on = 1'b1;
    for (int i = 0; i < 8000; i++) begin
      if (oe) oe_n++;
      if (oe && !prev_oe) rises++;
      prev_oe = oe;
      if (busy) busy_n++;
      if (done) begin
        done_n++;
        if (done_at < 0) done_at = i;
      end
      if (pk == 1 && i == poke) begin cmd_op = 2'b10; cmd_valid = 1'b1; end
      if (pk == 1 && i == poke + 1) cmd_valid = 1'b0;
      if (pk == 2 && i == poke) od_sel = ~od;
      if (done_at >= 0 && i >= done_at + 3) break;
      @(negedge clk);
    end
    win_on = 1'b0;
    if (done_at < 0) chk(1'b0, "R8", "operation never completed", 0, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL R8 watchdog expired: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int  oe_n, busy_n, done_n, rises;
    int  s;
    bit  pp, pr;
    string rq;

    repeat (3) @(negedge clk);
    // R1: state right after reset, while still in reset and after release
    chk(busy == 1'b0, "R1", "busy in reset", int'(busy), 0);
    chk(oe == 1'b0,   "R1", "line_oe in reset", int'(oe), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(done == 1'b0, "R1", "done after reset", int'(done), 0);
    chk(pres == 1'b0, "R1", "presence after reset", int'(pres), 0);
    chk(rbit == 1'b0, "R1", "rbit after reset", int'(rbit), 0);
    chk(busy == 1'b0 && oe == 1'b0, "R1", "idle outputs", int'({busy, oe}), 0);

    // Sweep: both speeds, every operation kind, slave silent and answering
    for (int od = 0; od < 2; od++) begin
      for (int k = 0; k < 4; k++) begin
        for (int act = 0; act < 2; act++) begin
          int lo, hi, low, fin;
          logic [1:0] op;
          logic bv;
          low = e_low(k, od[0]);
          fin = e_fin(k, od[0]);
          lo = 0; hi = 0;
          if (k == 0 && act == 1) begin
            lo = (low + (od ? 4 : 30)) * C;
            hi = (low + (od ? 28 : 270)) * C;
          end
          if (k == 3 && act == 1) begin
            lo = 0;
            hi = (od ? 6 : 90) * C;
          end
          op = (k == 0) ? 2'b00 : (k == 3) ? 2'b10 : 2'b01;
          bv = (k == 2);
          pp = pres; pr = rbit;
          run_op(op, bv, od[0], lo, hi, 0, 0, oe_n, busy_n, done_n, rises);
          rq = (k == 0) ? (od ? "R3" : "R2") : (k == 3) ? "R6" : "R5";
          chk(oe_n == low * C, rq, "low width cycles", oe_n, low * C);
          chk(rises == 1, "R5", "single low phase at start", rises, 1);
          chk(busy_n == fin * C, (k == 0) ? rq : "R7", "busy length cycles", busy_n, fin * C);
          chk(done_n == 1, "R8", "done pulse count", done_n, 1);
          if (k == 0) begin
            chk(pres == act[0], "R4", "presence result", int'(pres), act);
            chk(rbit == pr, "R6", "rbit held over reset", int'(rbit), int'(pr));
          end else if (k == 3) begin
            chk(rbit == !act[0], "R6", "read bit result", int'(rbit), int'(!act[0]));
            chk(pres == pp, "R4", "presence held over read", int'(pres), int'(pp));
          end else begin
            chk(pres == pp, "R4", "presence held over write", int'(pres), int'(pp));
            chk(rbit == pr, "R6", "rbit held over write", int'(rbit), int'(pr));
          end
        end
      end
    end

    // R9: stray strobe in the middle of a standard write-zero
    run_op(2'b01, 1'b0, 1'b0, 0, 0, 40, 1, oe_n, busy_n, done_n, rises);
    chk(oe_n == e_low(1, 1'b0) * C, "R9", "low width with stray strobe", oe_n, e_low(1, 1'b0) * C);
    chk(busy_n == e_fin(1, 1'b0) * C, "R9", "busy with stray strobe", busy_n, e_fin(1, 1'b0) * C);
    chk(done_n == 1, "R9", "no second operation", done_n, 1);

    // R11: speed input flips during an overdrive write-zero
    run_op(2'b01, 1'b0, 1'b1, 0, 0, 5, 2, oe_n, busy_n, done_n, rises);
    chk(oe_n == e_low(1, 1'b1) * C, "R11", "low width after speed flip", oe_n, e_low(1, 1'b1) * C);
    chk(busy_n == e_fin(1, 1'b1) * C, "R11", "busy after speed flip", busy_n, e_fin(1, 1'b1) * C);
    od_sel = 1'b0;

    // R4: narrow response windows around the standard presence instant
    s = (480 + 70) * 2 * C;
    run_op(2'b00, 1'b0, 1'b0, s - 10, s + 10, 0, 0, oe_n, busy_n, done_n, rises);
    chk(pres == 1'b1, "R4", "response spanning sample instant", int'(pres), 1);
    run_op(2'b00, 1'b0, 1'b0, s - 200, s - 10, 0, 0, oe_n, busy_n, done_n, rises);
    chk(pres == 1'b0, "R4", "response ending before sample instant", int'(pres), 0);

    // R10: opcode 11 while idle
    @(negedge clk);
    cmd_op = 2'b11; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    busy_n = 0; oe_n = 0;
    for (int i = 0; i < 10; i++) begin
      if (busy) busy_n++;
      if (oe) oe_n++;
      @(negedge clk);
    end
    chk(busy_n == 0, "R10", "busy cycles after none opcode", busy_n, 0);
    chk(oe_n == 0, "R10", "drive cycles after none opcode", oe_n, 0);
    chk(oe == 1'b0 && busy == 1'b0, "R12", "idle line not driven", int'(oe), 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule